// File: doc/BRIEF.md
# Multiplexed Bus Address Reconstructor

This block sits behind a single processor chip-select whose bus shares lines between address and data. From the address lines the processor presents, plus whatever the upper data byte lane carried during address phases, it rebuilds a 28-bit local address. It decodes that address into four active-low local chip-selects and an active-low select for an internal register space, and forwards a one-cycle access strobe, the write flag and the write data.

A two-bit mode input picks how the address is formed. In wide mode the upper data lane carries address bits that are captured on two address-latch strobes. In reduced byte-lane mode a compressed address is spread out to the top of the local space. In paired byte-lane mode two successive processor accesses form one local access: the first one only deposits address bits and its data is dropped, and the second one performs the transfer. Accesses aimed at the register space skip the pairing and finish in one access.

Top module: `mbus_addr_rebuild`

## Requirements
- R1: Rebuilt address bits 27..26 pick the region: 00 drives cs_n_o[0], 01 drives cs_n_o[1], 10 drives cs_n_o[2]; at most one of cs_n_o and reg_sel_no is low in any cycle.
- R2: When bits 27..26 are 11, bit 25 clear selects cs_n_o[3] and bit 25 set selects reg_sel_no instead.
- R3: Mode 00 (and the spare code 11) is wide mode: a cycle with ale_hi_i high stores data_i[11:8] as address bits 27..24, a cycle with ale_lo_i high stores data_i[15:8] as bits 15..8; the access address is {stored 27..24, pa_hi_i, stored 15..8, pa_lo_i}, one access per transfer.
- R4: Mode 01 is reduced mode: bits 27..20 come from pa_hi_i, bits 7..1 from pa_lo_i[7:1], and bits 19..8 and bit 0 are zero.
- R5: Mode 10 is paired mode. In its first access pa_hi_i[3:0] is stored as bits 27..24 and pa_lo_i as bits 7..0; that access raises no strobe and no select, its data is discarded, addr_o and wdata_o keep their previous values, and a read returns zero.
- R6: The second paired access forwards one transfer to {stored 27..24, pa_hi_i, pa_lo_i, stored 7..0} using its own data and write flag, and the next access is again a first access.
- R7: In paired mode a first access whose pa_hi_i[3:1] are all ones goes to the register space at once as {pa_hi_i[3:0], 16 zero bits, pa_lo_i} and leaves the pair sequence at its first step.
- R8: Any cycle with mode_i other than 10, and reset, return the pair sequence to its first step.
- R9: An access sampled at clock edge N (acc_i high) shows its result from edge N until edge N+1: strobe_o high for exactly that cycle, the chosen select low, addr_o, we_o and wdata_o updated; outside such cycles every select is high.
- R10: rdata_o equals ext_rdata_i during the cycle of a forwarded read and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 wide, 01 reduced, 10 paired, 11 as wide |
| ale_hi_i | input | 1 | Address phase carrying bits 27..24 on data_i[11:8] |
| ale_lo_i | input | 1 | Address phase carrying bits 15..8 on data_i[15:8] |
| acc_i | input | 1 | One-cycle data phase of a processor access |
| we_i | input | 1 | Access is a write |
| pa_hi_i | input | 8 | Presented address bits 23..16 |
| pa_lo_i | input | 8 | Presented address bits 7..0 |
| data_i | input | 16 | Data lanes from the processor |
| ext_rdata_i | input | 16 | Read data from the selected local target |
| addr_o | output | 28 | Rebuilt local address |
| cs_n_o | output | 4 | Local chip-selects, active low |
| reg_sel_no | output | 1 | Register-space select, active low |
| strobe_o | output | 1 | Forwarded access strobe |
| we_o | output | 1 | Forwarded write flag |
| wdata_o | output | 16 | Forwarded write data |
| rdata_o | output | 16 | Read data returned to the processor |

## Verification
The assertions watch every cycle for the select outputs staying mutually exclusive and silent outside a strobe, the strobe following an access by one cycle, register-select landing only on addresses with bits 27..25 set, the first paired access staying silent, the register bypass and the pair-step clearing when the mode leaves paired mode. The exact rebuilt address values per mode, the discarding of the first access's data, the holding of addr_o and wdata_o across a dummy access and the returned read data can only be shown by the bench's sweeps, which compute each expected address arithmetically over all top nibbles, all reduced high bytes and all paired nibbles.

// File: rtl/mbus_rb_pkg.sv
package mbus_rb_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE  = 2'b00,
    MODE_RED   = 2'b01,
    MODE_PAIR  = 2'b10,
    MODE_SPARE = 2'b11
  } bus_mode_e;

  // Bits that split the top region into chip-select and register space.
  localparam int unsigned SPLIT_BITS = 3;

endpackage

// File: rtl/mbus_hi_latch.sv
module mbus_hi_latch #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ale_hi_i,
  input  logic              ale_lo_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [NIB_W-1:0]  top_o,
  output logic [LANE_W-1:0] mid_o
);

  logic [NIB_W-1:0]  top_q;
  logic [LANE_W-1:0] mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      mid_q <= '0;
    end else if (en_i) begin
      if (ale_hi_i) top_q <= lane_i[NIB_W-1:0];
      if (ale_lo_i) mid_q <= lane_i;
    end
  end

  assign top_o = top_q;
  assign mid_o = mid_q;

endmodule

// File: rtl/mbus_pair_seq.sv
module mbus_pair_seq #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_mode_i,
  input  logic              acc_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [LANE_W-1:0] lo_i,
  output logic              phase_o,
  output logic              reg_first_o,
  output logic              dummy_o,
  output logic [NIB_W-1:0]  nib_o,
  output logic [LANE_W-1:0] lo_o
);

  logic              phase_q;
  logic [NIB_W-1:0]  nib_q;
  logic [LANE_W-1:0] lo_q;
  logic              reg_first;

  // Register space: every nibble bit above the chip-select-4 split set.
  assign reg_first = pair_mode_i && !phase_q && (&nib_i[NIB_W-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      nib_q   <= '0;
      lo_q    <= '0;
    end else if (!pair_mode_i) begin
      phase_q <= 1'b0;
    end else if (acc_i) begin
      if (phase_q) begin
        phase_q <= 1'b0;
      end else if (!reg_first) begin
        phase_q <= 1'b1;
        nib_q   <= nib_i;
        lo_q    <= lo_i;
      end
    end
  end

  assign phase_o     = phase_q;
  assign reg_first_o = reg_first;
  assign dummy_o     = pair_mode_i && !phase_q && !reg_first;
  assign nib_o       = nib_q;
  assign lo_o        = lo_q;

endmodule

// File: rtl/mbus_addr_map.sv
module mbus_addr_map
  import mbus_rb_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned ADDR_W = NIB_W + 3 * LANE_W
) (
  input  bus_mode_e         mode_i,
  input  logic [LANE_W-1:0] pa_hi_i,
  input  logic [LANE_W-1:0] pa_lo_i,
  input  logic [NIB_W-1:0]  wide_top_i,
  input  logic [LANE_W-1:0] wide_mid_i,
  input  logic              phase_i,
  input  logic              reg_first_i,
  input  logic [NIB_W-1:0]  pair_nib_i,
  input  logic [LANE_W-1:0] pair_lo_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned RED_GAP = ADDR_W - 2 * LANE_W;

  logic [ADDR_W-1:0] wide_addr;
  logic [ADDR_W-1:0] red_addr;
  logic [ADDR_W-1:0] pair_addr;
  logic [ADDR_W-1:0] regd_addr;

  assign wide_addr = {wide_top_i, pa_hi_i, wide_mid_i, pa_lo_i};
  assign red_addr  = {pa_hi_i, {RED_GAP{1'b0}}, pa_lo_i[LANE_W-1:1], 1'b0};
  assign pair_addr = {pair_nib_i, pa_hi_i, pa_lo_i, pair_lo_i};
  assign regd_addr = {pa_hi_i[NIB_W-1:0], {(2*LANE_W){1'b0}}, pa_lo_i};

  always_comb begin
    unique case (mode_i)
      MODE_RED:  addr_o = red_addr;
      MODE_PAIR: begin
        if (phase_i)          addr_o = pair_addr;
        else if (reg_first_i) addr_o = regd_addr;
        else                  addr_o = '0;
      end
      default:   addr_o = wide_addr;
    endcase
  end

endmodule

// File: rtl/mbus_region_dec.sv
module mbus_region_dec
  import mbus_rb_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned RGN_W = $clog2(NUM_CS)
) (
  input  logic [SPLIT_BITS-1:0] top_bits_i,
  output logic [NUM_CS-1:0]     cs_hit_o,
  output logic                  reg_hit_o
);

  logic [RGN_W-1:0] rgn;
  logic             split;

  assign rgn   = top_bits_i[SPLIT_BITS-1 -: RGN_W];
  assign split = top_bits_i[0];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    if (i == NUM_CS - 1) begin : g_last
      assign cs_hit_o[i] = (rgn == RGN_W'(i)) && !split;
    end else begin : g_full
      assign cs_hit_o[i] = (rgn == RGN_W'(i));
    end
  end

  assign reg_hit_o = (rgn == RGN_W'(NUM_CS - 1)) && split;

endmodule

// File: rtl/mbus_addr_rebuild.sv
module mbus_addr_rebuild
  import mbus_rb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned ADDR_W = NIB_W + 3 * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ale_hi_i,
  input  logic              ale_lo_i,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [LANE_W-1:0] pa_hi_i,
  input  logic [LANE_W-1:0] pa_lo_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              reg_sel_no,
  output logic              strobe_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  bus_mode_e         mode;
  logic              wide_en;
  logic [NIB_W-1:0]  wide_top;
  logic [LANE_W-1:0] wide_mid;
  logic              pair_phase;
  logic              reg_first;
  logic              dummy;
  logic [NIB_W-1:0]  pair_nib;
  logic [LANE_W-1:0] pair_lo;
  logic [ADDR_W-1:0] next_addr;
  logic [NUM_CS-1:0] cs_hit;
  logic              reg_hit;
  logic              fwd;

  assign mode    = bus_mode_e'(mode_i);
  assign wide_en = (mode == MODE_WIDE) || (mode == MODE_SPARE);

  mbus_hi_latch #(
    .LANE_W (LANE_W),
    .NIB_W  (NIB_W)
  ) u_hi_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wide_en),
    .ale_hi_i (ale_hi_i),
    .ale_lo_i (ale_lo_i),
    .lane_i   (data_i[DATA_W-1 -: LANE_W]),
    .top_o    (wide_top),
    .mid_o    (wide_mid)
  );

  mbus_pair_seq #(
    .LANE_W (LANE_W),
    .NIB_W  (NIB_W)
  ) u_pair_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pair_mode_i (mode == MODE_PAIR),
    .acc_i       (acc_i),
    .nib_i       (pa_hi_i[NIB_W-1:0]),
    .lo_i        (pa_lo_i),
    .phase_o     (pair_phase),
    .reg_first_o (reg_first),
    .dummy_o     (dummy),
    .nib_o       (pair_nib),
    .lo_o        (pair_lo)
  );

  mbus_addr_map #(
    .LANE_W (LANE_W),
    .NIB_W  (NIB_W)
  ) u_addr_map (
    .mode_i      (mode),
    .pa_hi_i     (pa_hi_i),
    .pa_lo_i     (pa_lo_i),
    .wide_top_i  (wide_top),
    .wide_mid_i  (wide_mid),
    .phase_i     (pair_phase),
    .reg_first_i (reg_first),
    .pair_nib_i  (pair_nib),
    .pair_lo_i   (pair_lo),
    .addr_o      (next_addr)
  );

  mbus_region_dec #(
    .NUM_CS (NUM_CS)
  ) u_region_dec (
    .top_bits_i (next_addr[ADDR_W-1 -: SPLIT_BITS]),
    .cs_hit_o   (cs_hit),
    .reg_hit_o  (reg_hit)
  );

  assign fwd = acc_i && !dummy;

  logic              strobe_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NUM_CS-1:0] cs_n_q;
  logic              reg_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      cs_n_q   <= '1;
      reg_n_q  <= 1'b1;
    end else begin
      strobe_q <= fwd;
      cs_n_q   <= fwd ? ~cs_hit : '1;
      reg_n_q  <= fwd ? ~reg_hit : 1'b1;
      if (fwd) begin
        we_q    <= we_i;
        addr_q  <= next_addr;
        wdata_q <= data_i;
      end
    end
  end

  assign addr_o     = addr_q;
  assign cs_n_o     = cs_n_q;
  assign reg_sel_no = reg_n_q;
  assign strobe_o   = strobe_q;
  assign we_o       = we_q;
  assign wdata_o    = wdata_q;
  assign rdata_o    = (strobe_q && !we_q) ? ext_rdata_i : '0;

endmodule

// File: rtl/mbus_addr_rebuild_chk.sv
module mbus_addr_rebuild_chk #(
  parameter int unsigned ADDR_W = 28,
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              acc_i,
  input logic [7:0]        pa_hi_i,
  input logic              pair_phase,
  input logic [ADDR_W-1:0] addr_o,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic              reg_sel_no,
  input logic              strobe_o
);

  a_r1_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~cs_n_o, ~reg_sel_no}) <= 1);

  a_r2_reg_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_no |-> (addr_o[ADDR_W-1 -: 3] == 3'b111));

  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> ((&cs_n_o) && reg_sel_no));

  a_r9_select_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> ($countones({~cs_n_o, ~reg_sel_no}) == 1));

  a_r9_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (strobe_o || !$past(acc_i) || $past(mode_i) == 2'b10));

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> !strobe_o);

  a_r5_first_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && mode_i == 2'b10 && !pair_phase && !(&pa_hi_i[3:1])) |=> (!strobe_o && pair_phase));

  a_r6_second_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && mode_i == 2'b10 && pair_phase) |=> (strobe_o && !pair_phase));

  a_r7_reg_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && mode_i == 2'b10 && !pair_phase && (&pa_hi_i[3:1])) |=> (!reg_sel_no && !pair_phase));

  a_r8_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10) |=> !pair_phase);

endmodule

bind mbus_addr_rebuild mbus_addr_rebuild_chk #(
  .ADDR_W (ADDR_W),
  .NUM_CS (NUM_CS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .acc_i      (acc_i),
  .pa_hi_i    (pa_hi_i),
  .pair_phase (pair_phase),
  .addr_o     (addr_o),
  .cs_n_o     (cs_n_o),
  .reg_sel_no (reg_sel_no),
  .strobe_o   (strobe_o)
);

// File: tb/mbus_addr_rebuild_bench.sv
module mbus_addr_rebuild_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        ale_hi = 1'b0, ale_lo = 1'b0, acc = 1'b0, we = 1'b0;
  logic [7:0]  pa_hi = '0, pa_lo = '0;
  logic [15:0] data = '0, ext_rd = '0;
  logic [27:0] addr_o;
  logic [3:0]  cs_n;
  logic        reg_n, strobe, we_o;
  logic [15:0] wdata_o, rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbus_addr_rebuild u_mbus_addr_rebuild (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ale_hi_i(ale_hi), .ale_lo_i(ale_lo),
    .acc_i(acc), .we_i(we), .pa_hi_i(pa_hi), .pa_lo_i(pa_lo), .data_i(data),
    .ext_rdata_i(ext_rd), .addr_o(addr_o), .cs_n_o(cs_n), .reg_sel_no(reg_n),
    .strobe_o(strobe), .we_o(we_o), .wdata_o(wdata_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {reg_n, cs_n[3:0]} expected for an address
  function automatic logic [4:0] exp_sel(input logic [27:0] a);
    if (a[27:25] == 3'b111) return 5'b0_1111;
    return {1'b1, ~(4'b0001 << a[27:26])};
  endfunction

  task automatic ale_load(input logic [7:0] top, input logic [7:0] mid);
    @(negedge clk); data = {top, 8'h00}; ale_hi = 1;
    @(negedge clk); ale_hi = 0; data = {mid, 8'h00}; ale_lo = 1;
    @(negedge clk); ale_lo = 0;
  endtask

  // Access sampled at next posedge; returns at the following negedge.
  task automatic access(input logic [1:0] m, input logic [7:0] h, input logic [7:0] l,
                        input logic [15:0] d, input logic w, input logic [15:0] rd);
    @(negedge clk); mode = m; pa_hi = h; pa_lo = l; data = d; we = w; ext_rd = rd; acc = 1;
    @(negedge clk); acc = 0;
  endtask

  task automatic check_fwd(input string tag, input logic [27:0] ea, input logic [15:0] d,
                           input logic w, input logic [15:0] rd);
    logic [4:0] es;
    es = exp_sel(ea);
    chk(strobe === 1'b1, {tag, " R9 strobe"}, {31'd0, strobe}, 1);
    chk(addr_o === ea, {tag, " addr"}, {4'd0, addr_o}, {4'd0, ea});
    chk({reg_n, cs_n} === es, {tag, " R1 R2 select"}, {27'd0, reg_n, cs_n}, {27'd0, es});
    if (w) chk(wdata_o === d && we_o, {tag, " wdata"}, {16'd0, wdata_o}, {16'd0, d});
    else   chk(rdata_o === rd && !we_o, {tag, " R10 rdata"}, {16'd0, rdata_o}, {16'd0, rd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [27:0] ea;
    logic [27:0] prev_a;
    logic [15:0] prev_d;
    repeat (3) @(negedge clk);
    // Reset state (R9)
    chk(strobe === 0 && cs_n === 4'hF && reg_n === 1, "R9 reset quiet", {26'd0, strobe, reg_n, cs_n}, 32'h1F);
    chk(addr_o === 0 && rdata_o === 0, "R10 reset outputs", {4'd0, addr_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 wide mode sweep over all top nibbles (also R1, R2)
    for (int t = 0; t < 16; t++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] top, mid, h, l;
        logic [15:0] d;
        logic w;
        top = 8'(t | (k << 4) | 8'hA0);
        mid = 8'(t * 17 + k * 29);
        h = 8'(t * 7 + k * 61);
        l = 8'(k * 37 + t);
        d = 16'(t * 4099 + k * 311);
        w = k[0];
        ale_load(top, mid);
        access(k == 3 ? 2'b11 : 2'b00, h, l, d, w, ~d);
        ea = (28'(t) << 24) | (28'(h) << 16) | (28'(mid) << 8) | 28'(l);
        check_fwd("R3 wide", ea, d, w, ~d);
        @(negedge clk);
        chk(strobe === 0 && cs_n === 4'hF && reg_n === 1 && rdata_o === 0, "R9 R10 one cycle",
            {31'd0, strobe}, 0);
      end
    end

    // R4 reduced mode sweep over every high byte
    for (int hv = 0; hv < 256; hv++) begin
      logic [7:0] l;
      logic [15:0] d;
      l = 8'(hv) ^ 8'h5B;
      d = 16'(hv * 257) ^ 16'h1234;
      access(2'b01, 8'(hv), l, d, hv[0], d + 16'd7);
      ea = (28'(hv) << 20) | 28'(l & 8'hFE);
      check_fwd("R4 reduced", ea, d, hv[0], d + 16'd7);
    end

    // R5 R6 R7 paired mode over every first nibble
    for (int n = 0; n < 16; n++) begin
      logic [7:0] h1, l1, h2, l2;
      logic [15:0] d1, d2;
      h1 = 8'(n) | 8'h90;
      l1 = 8'(n * 9 + 3);
      h2 = 8'(n * 13 + 5);
      l2 = 8'(~n * 3);
      d1 = 16'hDEAD ^ 16'(n);
      d2 = 16'(n * 1031 + 77);
      prev_a = addr_o;
      prev_d = wdata_o;
      if (n >= 14) begin
        access(2'b10, h1, l1, d2, 1'b1, 16'h0);
        ea = (28'(n) << 24) | 28'(l1);
        check_fwd("R7 reg bypass", ea, d2, 1'b1, 16'h0);
        chk(reg_n === 0, "R7 reg select", {31'd0, reg_n}, 0);
        // Next access must be a first (dummy) access again
        access(2'b10, 8'h03, 8'h11, 16'hBEEF, 1'b1, 16'h0);
        chk(strobe === 0, "R7 phase stays first", {31'd0, strobe}, 0);
        access(2'b10, 8'h22, 8'h33, 16'h4455, 1'b1, 16'h0);
        check_fwd("R7 R6 after bypass", (28'h3 << 24) | (28'h22 << 16) | (28'h33 << 8) | 28'h11,
                  16'h4455, 1'b1, 16'h0);
      end else begin
        access(2'b10, h1, l1, d1, n[0], 16'hF00D);
        chk(strobe === 0 && cs_n === 4'hF && reg_n === 1, "R5 dummy silent",
            {26'd0, strobe, reg_n, cs_n}, 32'h1F);
        chk(addr_o === prev_a && wdata_o === prev_d, "R5 outputs held",
            {4'd0, addr_o}, {4'd0, prev_a});
        chk(rdata_o === 0, "R5 dummy read zero", {16'd0, rdata_o}, 0);
        access(2'b10, h2, l2, d2, n[1], 16'(n) ^ 16'h7E7E);
        ea = (28'(n) << 24) | (28'(h2) << 16) | (28'(l2) << 8) | 28'(l1);
        check_fwd("R6 pair second", ea, d2, n[1], 16'(n) ^ 16'h7E7E);
      end
    end

    // R8 leaving paired mode clears the sequence
    access(2'b10, 8'h05, 8'h66, 16'h1111, 1'b1, 16'h0);
    chk(strobe === 0, "R8 first dummy", {31'd0, strobe}, 0);
    access(2'b01, 8'h40, 8'h02, 16'h2222, 1'b1, 16'h0);
    check_fwd("R8 reduced between", (28'h40 << 20) | 28'h02, 16'h2222, 1'b1, 16'h0);
    access(2'b10, 8'h06, 8'h77, 16'h3333, 1'b1, 16'h0);
    chk(strobe === 0, "R8 sequence restarted", {31'd0, strobe}, 0);
    chk(wdata_o === 16'h2222, "R5 first data discarded", {16'd0, wdata_o}, 32'h2222);
    access(2'b10, 8'h88, 8'h99, 16'h4444, 1'b1, 16'h0);
    check_fwd("R8 R6 completes", (28'h6 << 24) | (28'h88 << 16) | (28'h99 << 8) | 28'h77,
              16'h4444, 1'b1, 16'h0);

    // R8 reset mid-sequence
    access(2'b10, 8'h01, 8'h10, 16'h5555, 1'b1, 16'h0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    access(2'b10, 8'h02, 8'h20, 16'h6666, 1'b1, 16'h0);
    chk(strobe === 0, "R8 reset clears phase", {31'd0, strobe}, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule